// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave-side command interpreter for a byte-wide serial memory that is reached over a four-wire SPI link in mode 0. A fast system clock oversamples chip select, the serial clock, the serial input and an active-low pause input through synchronizers. The block then assembles each transaction: an 8-bit command byte, an optional two-byte address, and data bytes. All of these travel most significant bit first.

Read commands stream bytes out of an internal array model. The address steps forward after every byte and folds back to zero past the top of the array. Write commands pass each received byte to a page-write unit through a strobe with its address and data. The address stays inside the current page, and the same byte is stored in the array model. Status reads return a byte supplied by a neighbouring status/protection unit, and status writes hand the received byte to that unit. The serial output is presented as a data bit plus an enable, and the pad ring builds the tri-state from them.

Top module: `sfe_spi_front`

## Requirements
- R1: After reset, `so_oe` is low and none of `wren_pulse`, `wrdi_pulse`, `stat_wr_valid`, `wr_valid`, `wr_commit` is asserted.
- R2: A command byte is valid only when bits 7..4 are zero and bits 2..0 are neither 000 nor 111. Bit 3 is ignored. Low bits 110 give one `wren_pulse` and 100 give one `wrdi_pulse`. At most one of the four strobes is high in any cycle.
- R3: Command bits 101 shift `stat_rd` out on `so_d`, MSB first, with `so_oe` high. The byte repeats for as long as clocking continues.
- R4: Command bits 001 take the next byte and present it on `stat_wr_data` with a one-cycle `stat_wr_valid`.
- R5: Command bits 011 take a 16-bit address, MSB first, and then stream the array content from that address. The address rises by one per byte and wraps from the top of the array to zero.
- R6: Address bits at or above the array width (bit 8 and up at the default size) have no effect on reads or writes. `wr_addr` carries them as zero.
- R7: Command bits 010 take a 16-bit address. Each following byte gives one `wr_valid` with `wr_addr` and `wr_data`, and the byte is stored in the array. Only the low `PAGE_BITS` address bits advance, wrapping within the page. One `wr_commit` follows the rise of chip select when at least one byte arrived.
- R8: After an invalid command byte, `so_oe` stays low and no strobe fires until the next falling edge of chip select.
- R9: While `cs_n` is high, `so_oe` is low and serial input and clock edges have no effect.
- R10: The pause starts only when `hold_n` is low while SCK is low, and it ends only when `hold_n` is high while SCK is low. During the pause `so_oe` is low, SCK edges are ignored, and the bit position is kept.
- R11: While `busy` is high, any command other than 101 is treated as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| busy | input | 1 | Internal write cycle in progress |
| stat_rd | input | 8 | Status byte from the status/protection unit |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable |
| wren_pulse | output | 1 | Write-enable command strobe |
| wrdi_pulse | output | 1 | Write-disable command strobe |
| stat_wr_valid | output | 1 | Status write strobe |
| stat_wr_data | output | 8 | Status write byte |
| wr_valid | output | 1 | Data byte strobe to the page-write unit |
| wr_addr | output | 16 | Byte address of the strobed data |
| wr_data | output | 8 | Data byte |
| wr_commit | output | 1 | End of a write transaction with data |

## Verification
The assertions assume that SCK stays low and high for several system clocks per phase. They also assume that chip select never changes in the same synchronized cycle as an SCK edge, and that the pause input changes only when SCK is stable. The bench keeps to these conditions. It holds every SCK phase for eight clocks, moves chip select only while SCK is low with a margin on both sides, and changes `hold_n` either during an SCK low phase or in the middle of a high phase. Data, addresses, status bytes and the don't-care opcode bit come from a seeded random generator, and directed cases cover the wrap points, the pause and the busy window.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [2:0] OP_WRSR  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_READ  = 3'b011;
  localparam logic [2:0] OP_WRDI  = 3'b100;
  localparam logic [2:0] OP_RDSR  = 3'b101;
  localparam logic [2:0] OP_WREN  = 3'b110;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRD, ST_SWR, ST_REJ, ST_DONE
  } seq_st_t;

  function automatic logic opc_ok(input logic [7:0] b);
    return (b[7:4] == 4'd0) && (b[2:0] != 3'b000) && (b[2:0] != 3'b111);
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[i]}};
        else     chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sfe_link.sv
module sfe_link (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  input  logic hold_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic held
);
  logic sck_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      held  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_s)        held <= 1'b0;
      else if (!sck_s) held <= !hold_s;
    end
  end

  assign cs_fall  = cs_q & ~cs_s;
  assign cs_rise  = ~cs_q & cs_s;
  assign sck_rise = ~sck_q & sck_s & ~cs_s & ~held;
  assign sck_fall = sck_q & ~sck_s & ~cs_s & ~held;

  // R10
  hold_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cs_s) && (held != $past(held))) |-> !$past(sck_s));
endmodule

// File: rtl/sfe_mem.sv
module sfe_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
  import sfe_pkg::*;
#(
  parameter int AW = 16,
  parameter int MEM_AW = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              si_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              held,
  input  logic              busy,
  input  logic [7:0]        stat_i,
  input  logic [7:0]        mem_rdata,
  output logic [MEM_AW-1:0] mem_raddr,
  output logic              so_d,
  output logic              so_oe,
  output logic              wren_p,
  output logic              wrdi_p,
  output logic              swr_v,
  output logic [7:0]        swr_d,
  output logic              wr_v,
  output logic [AW-1:0]     wr_a,
  output logic [7:0]        wr_d,
  output logic              commit
);
  localparam int ADDR_BYTES = AW / 8;
  localparam int ACW = $clog2(ADDR_BYTES + 1);

  seq_st_t           st;
  logic [2:0]        bitcnt;
  logic [6:0]        shreg;
  logic [MEM_AW-1:0] addr;
  logic [ACW-1:0]    acnt;
  logic              is_rd, wrote;
  logic [6:0]        oshift;
  logic [7:0]        rx_byte, src;
  logic              byte_done, out_st;

  assign rx_byte   = {shreg, si_s};
  assign byte_done = sck_rise && (bitcnt == 3'd7) && (st != ST_IDLE);
  assign out_st    = (st == ST_RDAT) || (st == ST_SRD);
  assign src       = (st == ST_SRD) ? stat_i : mem_rdata;
  assign mem_raddr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; addr <= '0; acnt <= '0;
      is_rd <= 1'b0; wrote <= 1'b0; oshift <= '0; so_d <= 1'b0; so_oe <= 1'b0;
      wren_p <= 1'b0; wrdi_p <= 1'b0; swr_v <= 1'b0; swr_d <= '0;
      wr_v <= 1'b0; wr_a <= '0; wr_d <= '0; commit <= 1'b0;
    end else begin
      wren_p <= 1'b0; wrdi_p <= 1'b0; swr_v <= 1'b0; wr_v <= 1'b0; commit <= 1'b0;
      so_oe  <= !cs_s && !held && out_st;
      if (cs_rise) begin
        commit <= (st == ST_WDAT) && wrote;
        st     <= ST_IDLE;
      end else if (cs_fall) begin
        st <= ST_OPC; bitcnt <= '0; acnt <= '0; wrote <= 1'b0;
      end else begin
        if (sck_rise && st != ST_IDLE) begin
          shreg  <= rx_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              if (!opc_ok(rx_byte) || (busy && rx_byte[2:0] != OP_RDSR)) st <= ST_REJ;
              else begin
                case (rx_byte[2:0])
                  OP_WREN:  begin wren_p <= 1'b1; st <= ST_DONE; end
                  OP_WRDI:  begin wrdi_p <= 1'b1; st <= ST_DONE; end
                  OP_RDSR:  st <= ST_SRD;
                  OP_WRSR:  st <= ST_SWR;
                  OP_READ:  begin is_rd <= 1'b1; st <= ST_ADDR; end
                  OP_WRITE: begin is_rd <= 1'b0; st <= ST_ADDR; end
                  default:  st <= ST_REJ;
                endcase
              end
            end
            ST_ADDR: begin
              addr <= MEM_AW'({addr, rx_byte});
              acnt <= acnt + ACW'(1);
              if (acnt == ACW'(ADDR_BYTES - 1)) st <= is_rd ? ST_RDAT : ST_WDAT;
            end
            ST_RDAT: addr <= addr + MEM_AW'(1);
            ST_WDAT: begin
              wr_v  <= 1'b1;
              wr_a  <= AW'(addr);
              wr_d  <= rx_byte;
              wrote <= 1'b1;
              addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + PAGE_BITS'(1);
            end
            ST_SWR: begin
              swr_v <= 1'b1;
              swr_d <= rx_byte;
              st    <= ST_DONE;
            end
            default: ;
          endcase
        end
        if (sck_fall && out_st) begin
          if (bitcnt == 3'd0) begin
            so_d   <= src[7];
            oshift <= src[6:0];
          end else begin
            so_d   <= oshift[6];
            oshift <= {oshift[5:0], 1'b0};
          end
        end
      end
    end
  end

  // R9
  cs_idle_oe_chk: assert property (@(posedge clk) disable iff (rst) cs_s |=> !so_oe);
  // R10
  hold_oe_chk: assert property (@(posedge clk) disable iff (rst) held |=> !so_oe);
  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wren_p, wrdi_p, swr_v, wr_v}));
  // R7
  commit_cs_chk: assert property (@(posedge clk) disable iff (rst) commit |-> cs_s);
  // R6
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_v |-> ((wr_a >> MEM_AW) == '0));
  // R8
  rej_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REJ) |=> !wr_v && !swr_v && !wren_p && !wrdi_p);
endmodule

// File: rtl/sfe_spi_front.sv
module sfe_spi_front #(
  parameter int AW = 16,
  parameter int MEM_AW = 8,
  parameter int PAGE_BITS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  input  logic          busy,
  input  logic [7:0]    stat_rd,
  output logic          so_d,
  output logic          so_oe,
  output logic          wren_pulse,
  output logic          wrdi_pulse,
  output logic          stat_wr_valid,
  output logic [7:0]    stat_wr_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);
  logic [3:0] pins_s;
  logic cs_s, sck_s, hold_s, si_s;
  logic sck_rise, sck_fall, cs_fall, cs_rise, held;
  logic [MEM_AW-1:0] mem_raddr;
  logic [7:0] mem_rdata;

  sfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, hold_n, si}), .q(pins_s));
  assign {cs_s, sck_s, hold_s, si_s} = pins_s;

  sfe_link u_link (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .held(held));

  sfe_seq #(.AW(AW), .MEM_AW(MEM_AW), .PAGE_BITS(PAGE_BITS)) u_seq (
    .clk(clk), .rst(rst), .cs_s(cs_s), .si_s(si_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise), .held(held),
    .busy(busy), .stat_i(stat_rd), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .so_d(so_d), .so_oe(so_oe), .wren_p(wren_pulse), .wrdi_p(wrdi_pulse),
    .swr_v(stat_wr_valid), .swr_d(stat_wr_data), .wr_v(wr_valid),
    .wr_a(wr_addr), .wr_d(wr_data), .commit(wr_commit));

  sfe_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .we(wr_valid), .waddr(wr_addr[MEM_AW-1:0]), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata));
endmodule

// File: tb/sim_sfe_spi_front.sv
module sim_sfe_spi_front;
  localparam int DEPTH = 256;
  localparam int PAGE = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] stat_rd = 8'h00;
  logic so_d, so_oe, wren_pulse, wrdi_pulse, stat_wr_valid, wr_valid, wr_commit;
  logic [7:0] stat_wr_data, wr_data;
  logic [15:0] wr_addr;

  int nvec = 0, nfail = 0;
  int n_wren = 0, n_wrdi = 0, n_swr = 0, n_wr = 0, n_commit = 0, n_oe = 0;
  logic [7:0] last_swr = 8'h00;
  logic [15:0] log_a [64];
  logic [7:0]  log_d [64];
  logic [7:0]  exp_mem [DEPTH];
  bit done = 0;

  always #2 clk = ~clk;

  sfe_spi_front u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .busy(busy), .stat_rd(stat_rd), .so_d(so_d), .so_oe(so_oe),
    .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse), .stat_wr_valid(stat_wr_valid),
    .stat_wr_data(stat_wr_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit));

  always @(negedge clk) begin
    if (!rst) begin
      if (wren_pulse) n_wren++;
      if (wrdi_pulse) n_wrdi++;
      if (stat_wr_valid) begin n_swr++; last_swr = stat_wr_data; end
      if (wr_valid) begin log_a[n_wr % 64] = wr_addr; log_d[n_wr % 64] = wr_data; n_wr++; end
      if (wr_commit) n_commit++;
      if (so_oe) n_oe++;
    end
  end

  function automatic logic [7:0] mem_at(input int a);
    return exp_mem[a % DEPTH];
  endfunction

  function automatic int page_step(input int a);
    return (a / PAGE) * PAGE + ((a % PAGE) + 1) % PAGE;
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r, output logic o);
    si = b; waitc(8); r = so_d; o = so_oe; sck = 1'b1; waitc(8); sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all, output logic oe_any);
    logic r, o;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bitx(tx[i], r, o);
      rx[i] = r; oe_all &= o; oe_any |= o;
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; waitc(8); endtask
  task automatic cs_hi(); waitc(8); cs_n = 1'b1; waitc(10); endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx; logic a, b;
    xfer(tx, rx, a, b);
  endtask

  function automatic logic [7:0] opc(input logic [2:0] lo);
    return {4'b0000, 1'($urandom % 2), lo};
  endfunction

  task automatic rd_check(input logic [15:0] a, input int n, input string rq);
    logic [7:0] rx; logic oa, on;
    cs_lo(); send(opc(3'b011)); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xfer(8'($urandom), rx, oa, on);
      check(rq, rx, mem_at(int'(a[7:0]) + i));
      check({rq, " oe"}, oa, 1'b1);
    end
    cs_hi();
  endtask

  task automatic wr_page(input logic [15:0] a, input int n, input string rq);
    int base, cur; logic [7:0] d;
    base = n_wr; cur = int'(a[7:0]);
    cs_lo(); send(opc(3'b010)); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom); send(d); exp_mem[cur] = d;
      waitc(2);
      check({rq, " addr"}, log_a[(base + i) % 64], 32'(cur));
      check({rq, " data"}, log_d[(base + i) % 64], d);
      cur = page_step(cur);
    end
    cs_hi();
  endtask

  initial begin
    logic [7:0] rx, v; logic oa, on, r, o;
    int c0, c1, c2, c3, c4;
    void'($urandom(32'd4711));
    waitc(10); rst = 1'b0; waitc(5);
    // R1 reset state
    check("R1 so_oe", so_oe, 1'b0);
    check("R1 strobes", {wren_pulse, wrdi_pulse, stat_wr_valid, wr_valid, wr_commit}, 5'd0);

    // R7 fill the array page by page; upper address bits random (R6)
    for (int pg = 0; pg < DEPTH / PAGE; pg++) begin
      c0 = n_commit;
      wr_page({8'($urandom), 8'(pg * PAGE)}, PAGE, "R7 fill");
      check("R7 commit", n_commit, c0 + 1);
    end

    // R5 R6 random reads with random upper address bits
    for (int k = 0; k < 6; k++) rd_check(16'($urandom), 3, "R5 R6 read");
    // R5 wrap at the top of the array
    rd_check(16'hC0FE, 4, "R5 wrap");

    // R7 page wrap: offset 14 of page 0x20, four bytes
    wr_page(16'h002E, 4, "R7 page wrap");
    rd_check(16'h0020, PAGE, "R7 readback");

    // R7 write with no data bytes gives no commit
    c0 = n_commit;
    cs_lo(); send(8'h02); send(8'h00); send(8'h10); cs_hi();
    check("R7 no commit", n_commit, c0);

    // R2 enable/disable strobes, bit 3 both ways
    c0 = n_wren; c1 = n_wrdi;
    cs_lo(); send(8'h06); cs_hi(); cs_lo(); send(8'h0E); cs_hi();
    check("R2 wren count", n_wren, c0 + 2);
    cs_lo(); send(8'h04); cs_hi(); cs_lo(); send(8'h0C); cs_hi();
    check("R2 wrdi count", n_wrdi, c1 + 2);
    check("R2 wren unchanged", n_wren, c0 + 2);

    // R3 status read repeats
    stat_rd = 8'($urandom);
    cs_lo(); send(opc(3'b101));
    for (int i = 0; i < 2; i++) begin
      xfer(8'($urandom), rx, oa, on);
      check("R3 status byte", rx, stat_rd);
      check("R3 oe", oa, 1'b1);
    end
    cs_hi();

    // R4 status write
    c0 = n_swr; v = 8'($urandom);
    cs_lo(); send(opc(3'b001)); send(v); cs_hi();
    check("R4 count", n_swr, c0 + 1);
    check("R4 data", last_swr, v);

    // R8 invalid command bytes, followed by bytes that would be valid
    foreach (rx[i]) ;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] bad;
      case (k)
        0: bad = 8'h80; 1: bad = 8'h07; 2: bad = 8'h08; default: bad = 8'h13;
      endcase
      c0 = n_wren; c1 = n_wr; c2 = n_swr; c3 = n_oe; c4 = n_wrdi;
      cs_lo(); send(bad); send(8'h06); send(8'h01); send(8'h03); send(8'h00);
      cs_hi();
      check("R8 no oe", n_oe, c3);
      check("R8 no strobes", (n_wren - c0) + (n_wr - c1) + (n_swr - c2) + (n_wrdi - c4), 0);
    end
    // R8 next falling edge of chip select restores operation
    rd_check(16'h0033, 2, "R8 recovery");

    // R9 clocking with chip select high
    c0 = n_wren; c1 = n_wr; c3 = n_oe;
    xfer(8'h06, rx, oa, on); xfer(8'h02, rx, oa, on); xfer(8'h55, rx, oa, on);
    check("R9 no oe", n_oe, c3);
    check("R9 no strobes", (n_wren - c0) + (n_wr - c1), 0);
    rd_check(16'h0040, 1, "R9 after idle");

    // R10 pause in mid byte, SCK toggles ignored, bit position kept
    cs_lo(); send(8'h03); send(8'h00); send(8'h55);
    for (int i = 7; i >= 4; i--) begin bitx(1'($urandom), r, o); rx[i] = r; end
    hold_n = 1'b0; waitc(8);
    check("R10 oe in pause", so_oe, 1'b0);
    for (int t = 0; t < 2; t++) begin sck = 1'b1; si = ~si; waitc(8); sck = 1'b0; waitc(8); end
    check("R10 oe still paused", so_oe, 1'b0);
    hold_n = 1'b1; waitc(8);
    for (int i = 3; i >= 0; i--) begin bitx(1'($urandom), r, o); rx[i] = r; end
    check("R10 byte after pause", rx, mem_at(8'h55));
    // R10 pause input low only while SCK high: no effect
    oa = 1'b1;
    si = 1'b0; waitc(8); rx[7] = so_d; oa &= so_oe; sck = 1'b1; waitc(2);
    hold_n = 1'b0; waitc(3); hold_n = 1'b1; waitc(3); sck = 1'b0;
    for (int i = 6; i >= 0; i--) begin bitx(1'($urandom), r, o); rx[i] = r; oa &= o; end
    check("R10 glitch byte", rx, mem_at(8'h56));
    check("R10 glitch oe", oa, 1'b1);
    cs_hi();

    // R11 busy window
    busy = 1'b1;
    c0 = n_wren; c1 = n_wr; c3 = n_oe;
    cs_lo(); send(8'h06); cs_hi();
    cs_lo(); send(8'h03); send(8'h00); send(8'h10); send(8'h00); cs_hi();
    cs_lo(); send(8'h02); send(8'h00); send(8'h10); send(8'hAA); cs_hi();
    check("R11 wren ignored", n_wren, c0);
    check("R11 read ignored", n_oe, c3);
    check("R11 write ignored", n_wr, c1);
    stat_rd = 8'hFF;
    cs_lo(); send(8'h05); xfer(8'h00, rx, oa, on); cs_hi();
    check("R11 status while busy", rx, 8'hFF);
    busy = 1'b0;
    rd_check(16'h0010, 1, "R11 data intact");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule